// File: doc/BRIEF.md
# Read address channel protocol checker

This block is a passive observer placed on the read address channel of an AXI3-style interface. It watches the valid/ready handshake and the request fields (identifier, address, burst length, transfer size, burst type, lock type, cache attributes and protection attributes). It never drives the bus. When either side of the channel breaks a handshake rule or a field-legality rule, the block raises a sticky error bit dedicated to that rule. A single combined error output summarises all of them.

A separate sticky warning reports a subordinate that keeps the manager waiting too long. This is a recommended practice rather than a hard rule, so it does not feed the combined error. The data bus width and the wait threshold are parameters. All flags clear only on the active-low asynchronous reset, so the block can sit in silicon or in a long simulation and be read at the end.

Each flag is registered. It rises on the clock edge that samples the offending cycle and is visible right after that edge.

Top module: `ar_chan_monitor`

## Requirements
- R1: While `arvalid`=1 and `arready`=0 in one cycle, each request field must be unchanged in the next cycle if `arvalid` is still 1. A change sets `err_flags` bit 0 for the ID, 1 for the address, 2 for the length, 3 for the size, 4 for the burst type, 5 for the lock type, 6 for the cache attributes and 7 for the protection attributes. If the request is held steady until accepted, no bit is set.
- R2: After a cycle with `arvalid`=1 and `arready`=0, a cycle with `arvalid`=0 sets bit 8.
- R3: `arvalid`=1 in the first clock cycle after `rst_n` is released sets bit 9. The same request in any later cycle does not set it.
- R4: An INCR burst (`arburst`=2'b01) sets bit 10 when the last byte address reaches a different 4 KB region than the start address. The last byte address is the start address aligned down to 2^`arsize`, plus (`arlen`+1)·2^`arsize`, minus 1. A carry out of the top of the address space counts as crossing. FIXED (2'b00) and WRAP (2'b10) bursts never set bit 10.
- R5: A WRAP burst whose address is not a multiple of 2^`arsize` sets bit 11.
- R6: A WRAP burst whose `arlen` is not 1, 3, 7 or 15 sets bit 12.
- R7: An `arsize` for which 2^`arsize` is larger than DATA_W/8 sets bit 13.
- R8: The reserved codes set their own bits: `arburst`=2'b11 sets bit 14 and `arlock`=2'b11 sets bit 15.
- R9: `arcache[1]`=0 together with a nonzero `arcache[3:2]` sets bit 16.
- R10: The field rules R4 to R9 apply only in cycles with `arvalid`=1. Illegal fields in a cycle with `arvalid`=0 set nothing.
- R11: Reset clears every flag. Every flag then stays set until the next reset. `err_any` is 1 exactly when some bit of `err_flags` is 1.
- R12: `warn_slow` is set when `arvalid`=1 and `arready`=0 for more than MAX_WAIT consecutive cycles. A wait of exactly MAX_WAIT cycles does not set it. `warn_slow` never affects `err_any`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arvalid | input | 1 | Request valid from the manager |
| arready | input | 1 | Request accepted by the subordinate |
| arid | input | ID_W | Transaction identifier |
| araddr | input | ADDR_W | Start byte address |
| arlen | input | 4 | Beats minus one |
| arsize | input | 3 | Log2 of the bytes per beat |
| arburst | input | 2 | Burst type: 00 FIXED, 01 INCR, 10 WRAP, 11 reserved |
| arlock | input | 2 | Lock type; 11 is reserved |
| arcache | input | 4 | Cache attributes |
| arprot | input | 3 | Protection attributes |
| err_flags | output | 17 | Sticky per-rule error bits, numbered as in R1 to R9 |
| err_any | output | 1 | OR of all error bits |
| warn_slow | output | 1 | Sticky slow-acceptance warning |

## Verification
The bench sweeps every burst type, size and length against addresses near a 4 KB edge, a misaligned address and the very top of the address space. A checker that drops the carry out of the last-byte sum would miss the crossing at the top of memory. A checker that forgets to align the start address first would flag bursts that are legal.

For each field, the bench changes only that field during a stall. A wrong field-to-bit mapping, or a compare against the wrong cycle, would then show up as a stray or missing bit.

The wait threshold is probed at exactly MAX_WAIT and at MAX_WAIT+1 stalled cycles, which exposes an off-by-one in the counter. The bench also checks that a request in the first cycle after reset is flagged while the same request one cycle later is not.

// File: rtl/ar_chan_monitor.sv
module ar_chan_monitor #(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 4,
  parameter int MAX_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  input  logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [3:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  input  logic [1:0]        arlock,
  input  logic [3:0]        arcache,
  input  logic [2:0]        arprot,
  output logic [16:0]       err_flags,
  output logic              err_any,
  output logic              warn_slow
);

  localparam int BUS_BYTES = DATA_W / 8;
  localparam int SIZE_MAX  = $clog2(BUS_BYTES);
  localparam int WAIT_W    = $clog2(MAX_WAIT + 1) + 1;
  localparam int AW1       = ADDR_W + 1;

  logic              stall_now, stall_q, first_q;
  logic [ID_W-1:0]   id_h;
  logic [ADDR_W-1:0] addr_h;
  logic [3:0]        len_h;
  logic [2:0]        size_h;
  logic [1:0]        burst_h;
  logic [1:0]        lock_h;
  logic [3:0]        cache_h;
  logic [2:0]        prot_h;
  logic [7:0]        chg;
  logic [16:0]       hit, err_q;
  logic [WAIT_W-1:0] wait_q;
  logic              warn_q;

  assign stall_now = arvalid & ~arready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      first_q <= 1'b1;
      id_h    <= '0;
      addr_h  <= '0;
      len_h   <= '0;
      size_h  <= '0;
      burst_h <= '0;
      lock_h  <= '0;
      cache_h <= '0;
      prot_h  <= '0;
    end else begin
      stall_q <= stall_now;
      first_q <= 1'b0;
      if (stall_now) begin
        id_h    <= arid;
        addr_h  <= araddr;
        len_h   <= arlen;
        size_h  <= arsize;
        burst_h <= arburst;
        lock_h  <= arlock;
        cache_h <= arcache;
        prot_h  <= arprot;
      end
    end
  end

  assign chg = {arprot != prot_h, arcache != cache_h, arlock != lock_h,
                arburst != burst_h, arsize != size_h, arlen != len_h,
                araddr != addr_h, arid != id_h};

  logic [AW1-1:0] a_ext, sz_mask, span, last_b;
  logic           cross_4k, wrap_misal, wrap_badlen, size_big;

  assign a_ext    = {1'b0, araddr};
  assign sz_mask  = (AW1'(1) << arsize) - AW1'(1);
  assign span     = (AW1'(arlen) + AW1'(1)) << arsize;
  assign last_b   = (a_ext & ~sz_mask) + span - AW1'(1);
  assign cross_4k = (arburst == 2'b01) && (last_b[AW1-1:12] != a_ext[AW1-1:12]);

  assign wrap_misal  = (arburst == 2'b10) && ((a_ext & sz_mask) != '0);
  assign wrap_badlen = (arburst == 2'b10) && !(arlen inside {4'd1, 4'd3, 4'd7, 4'd15});
  assign size_big    = 32'(arsize) > SIZE_MAX;

  assign hit[7:0] = (stall_q && arvalid) ? chg : 8'd0;
  assign hit[8]   = stall_q & ~arvalid;
  assign hit[9]   = first_q & arvalid;
  assign hit[10]  = arvalid & cross_4k;
  assign hit[11]  = arvalid & wrap_misal;
  assign hit[12]  = arvalid & wrap_badlen;
  assign hit[13]  = arvalid & size_big;
  assign hit[14]  = arvalid & (arburst == 2'b11);
  assign hit[15]  = arvalid & (arlock == 2'b11);
  assign hit[16]  = arvalid & ~arcache[1] & (arcache[3:2] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      wait_q <= '0;
      warn_q <= 1'b0;
    end else begin
      err_q <= err_q | hit;
      if (!stall_now) wait_q <= '0;
      else if (wait_q != WAIT_W'(MAX_WAIT)) wait_q <= wait_q + WAIT_W'(1);
      if (stall_now && wait_q == WAIT_W'(MAX_WAIT)) warn_q <= 1'b1;
    end
  end

  assign err_flags = err_q;
  assign err_any   = |err_q;
  assign warn_slow = warn_q;

endmodule

// File: rtl/ar_chan_monitor_chk.sv
module ar_chan_monitor_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arvalid,
  input logic              arready,
  input logic [ADDR_W-1:0] araddr,
  input logic [2:0]        arsize,
  input logic [1:0]        arburst,
  input logic [3:0]        arcache,
  input logic [16:0]       err_flags,
  input logic              warn_slow
);
  localparam int SIZE_MAX = $clog2(DATA_W / 8);

  // R1
  a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arvalid && !arready) && arvalid && araddr != $past(araddr)) |=> err_flags[1]);

  // R2
  a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(arvalid && !arready) && !arvalid) |=> err_flags[8]);

  // R7
  a_r7_size_big: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && 32'(arsize) > SIZE_MAX) |=> err_flags[13]);

  // R8
  a_r8_burst_res: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && arburst == 2'b11) |=> err_flags[14]);

  // R9
  a_r9_cache_dep: assert property (@(posedge clk) disable iff (!rst_n)
    (arvalid && !arcache[1] && arcache[3:2] != 2'b00) |=> err_flags[16]);

  // R11
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags != '0) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R12
  a_r12_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    warn_slow |=> warn_slow);
endmodule

bind ar_chan_monitor ar_chan_monitor_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_ar_chan_monitor.sv
module test_ar_chan_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int ID_W = 4;
  localparam int MAX_WAIT = 4;
  localparam int SIZE_MAX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arvalid = 1'b0, arready = 1'b0;
  logic [ID_W-1:0] arid = '0;
  logic [ADDR_W-1:0] araddr = '0;
  logic [3:0] arlen = '0;
  logic [2:0] arsize = '0;
  logic [1:0] arburst = 2'b01, arlock = '0;
  logic [3:0] arcache = 4'b0011;
  logic [2:0] arprot = '0;
  logic [16:0] err_flags;
  logic err_any, warn_slow;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ar_chan_monitor #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_WAIT(MAX_WAIT)) i_ar_chan_monitor (
    .clk(clk), .rst_n(rst_n), .arvalid(arvalid), .arready(arready), .arid(arid),
    .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst), .arlock(arlock),
    .arcache(arcache), .arprot(arprot), .err_flags(err_flags), .err_any(err_any),
    .warn_slow(warn_slow));

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic base_payload();
    arid = 4'd0; araddr = 32'h100; arlen = 4'd0; arsize = 3'd2;
    arburst = 2'b01; arlock = 2'b00; arcache = 4'b0011; arprot = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; arvalid = 1'b0; arready = 1'b0;
    base_payload();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    arvalid = 1'b0; arready = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset state, R11
    do_reset();
    chk("R11", "reset flags", 32'(err_flags), 32'd0);
    chk("R11", "reset err_any", 32'(err_any), 32'd0);
    chk("R12", "reset warn", 32'(warn_slow), 32'd0);

    // R3: request in first cycle after release
    do_reset();
    arvalid = 1'b1; arready = 1'b1;
    @(negedge clk);
    idle(1);
    chk("R3", "first-cycle valid", 32'(err_flags), 32'(1 << 9));
    chk("R11", "err_any after R3", 32'(err_any), 32'd1);

    // R1: stability per field, f=8 means no change
    for (int f = 0; f <= 8; f++) begin
      do_reset();
      idle(1);
      arvalid = 1'b1; arready = 1'b0;
      @(negedge clk);
      case (f)
        0: arid = 4'd1;
        1: araddr = 32'h104;
        2: arlen = 4'd1;
        3: arsize = 3'd1;
        4: arburst = 2'b00;
        5: arlock = 2'b01;
        6: arcache = 4'b0010;
        7: arprot = 3'd1;
        default: ;
      endcase
      @(negedge clk);
      arready = 1'b1;
      @(negedge clk);
      idle(1);
      chk("R1", $sformatf("field %0d change", f), 32'(err_flags), (f == 8) ? 32'd0 : 32'(1 << f));
    end

    // R2: valid dropped during stall, then sticky per R11
    do_reset();
    idle(1);
    arvalid = 1'b1; arready = 1'b0;
    @(negedge clk);
    idle(1);
    chk("R2", "valid dropped", 32'(err_flags), 32'(1 << 8));
    idle(6);
    chk("R11", "sticky after idle", 32'(err_flags), 32'(1 << 8));
    chk("R11", "err_any sticky", 32'(err_any), 32'd1);
    do_reset();
    chk("R11", "cleared by reset", 32'(err_flags), 32'd0);

    // R10: illegal fields with valid low
    do_reset();
    arburst = 2'b11; arlock = 2'b11; arcache = 4'b1100; arsize = 3'd7; araddr = 32'hFFFF_FFFF;
    idle(3);
    chk("R10", "illegal fields while idle", 32'(err_flags), 32'd0);

    // R12: wait threshold
    for (int n = 1; n <= MAX_WAIT + 3; n++) begin
      do_reset();
      idle(1);
      arvalid = 1'b1; arready = 1'b0;
      repeat (n) @(negedge clk);
      arready = 1'b1;
      @(negedge clk);
      idle(1);
      chk("R12", $sformatf("warn after %0d stall cycles", n), 32'(warn_slow), 32'(n > MAX_WAIT));
      chk("R12", "warn does not feed err_any", 32'(err_any), 32'd0);
    end

    // R8/R9: lock and cache sweep
    for (int lk = 0; lk < 4; lk++) begin
      for (int c = 0; c < 16; c++) begin
        do_reset();
        idle(1);
        arlock = 2'(lk); arcache = 4'(c);
        arvalid = 1'b1; arready = 1'b1;
        @(negedge clk);
        idle(1);
        chk("R8", "lock reserved", 32'(err_flags[15]), 32'(lk == 3));
        chk("R9", "cache dependency", 32'(err_flags[16]), 32'(((c & 2) == 0) && ((c & 12) != 0)));
        chk("R11", "err_any", 32'(err_any), 32'((lk == 3) || (((c & 2) == 0) && ((c & 12) != 0))));
      end
    end

    // R4-R8 burst legality sweep
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 8; s++) begin
        for (int l = 0; l < 16; l++) begin
          for (int ai = 0; ai < 5; ai++) begin
            longint unsigned a, al, last;
            bit e_cross, e_mis, e_len, e_big, e_res;
            case (ai)
              0: a = 64'h0;
              1: a = 64'h0000_0FFE;
              2: a = 64'h0000_0F83;
              3: a = 64'h0000_7FC0;
              default: a = 64'hFFFF_FFFC;
            endcase
            al = a & ~((64'd1 << s) - 1);
            last = al + (64'(l + 1) << s) - 1;
            e_cross = (b == 1) && ((last >> 12) != (a >> 12));
            e_mis = (b == 2) && ((a & ((64'd1 << s) - 1)) != 0);
            e_len = (b == 2) && !(l == 1 || l == 3 || l == 7 || l == 15);
            e_big = s > SIZE_MAX;
            e_res = (b == 3);
            do_reset();
            idle(1);
            arburst = 2'(b); arsize = 3'(s); arlen = 4'(l); araddr = 32'(a);
            arvalid = 1'b1; arready = 1'b1;
            @(negedge clk);
            idle(1);
            chk("R4", "4KB crossing", 32'(err_flags[10]), 32'(e_cross));
            chk("R5", "wrap alignment", 32'(err_flags[11]), 32'(e_mis));
            chk("R6", "wrap length", 32'(err_flags[12]), 32'(e_len));
            chk("R7", "size vs bus", 32'(err_flags[13]), 32'(e_big));
            chk("R8", "burst reserved", 32'(err_flags[14]), 32'(e_res));
            chk("R3", "no stray low bits", 32'(err_flags[9:0]), 32'd0);
          end
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule